// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which of twelve interrupt sources a 16-bit processor core services next. Eleven sources are maskable: five external request lines, three timers, two DMA channels and one asynchronous serial port. The twelfth is a non-maskable input. The controller compares the pending requests by programmed priority and raises one interrupt at a time, together with a fixed type code for the source that won.

When the core acknowledges an interrupt, the winning source's in-service bit is set. An in-service source blocks a second request from itself. It also blocks every source whose priority is not strictly higher than the highest-priority entry in service, so higher-priority work can nest inside lower-priority work. The core writes an end-of-interrupt to retire the most urgent in-service entry. The first two external lines can each be switched into a special fully nested mode. In that mode the line may interrupt again at its own priority, even while its own in-service bit is set.

Masking, the core's own interrupt enable flag, and re-enabling that flag inside a service routine all belong to the core. The controller only decides whether a request is offered.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0. Every maskable source starts masked, at priority 7, with special nesting off, and the in-service set is empty.
- R2: Maskable source index i is numbered as follows: external lines are 0 to 4, timers 5 to 7, DMA 8 and 9, serial port 10. An unmasked requesting source raises `irq_o` with type code 0x20+i one clock after its request is sampled, and `irq_o` falls one clock after the request is withdrawn.
- R3: Configuration write at address i (0 to 10) sets these fields: `cfg_wdata_i[2:0]` is the priority (0 most urgent, 7 least), bit 3 is the mask (1 = masked) and bit 4 is special nesting. A masked source is never offered. A write takes effect one clock after it is sampled.
- R4: Among eligible sources the lowest priority value wins. Equal values are resolved in favour of the lower source index.
- R5: An acknowledge while `irq_o` is high sets the winner's in-service bit and drops `irq_o` on the next clock. The same source is then not offered again until its in-service bit is cleared.
- R6: While sources are in service, a request is offered only if its priority value is strictly below the smallest priority value in service. Equal and lower priorities wait.
- R7: Special nesting takes effect only for sources 0 and 1. With it set, such a source is offered when its priority value is at or below the smallest value in service, even while its own in-service bit is set. Bit 4 written to any other source has no effect.
- R8: A rising edge on `nmi_i` is latched as pending, without any mask. It outranks every maskable source and is offered with type code 0x02. While it is in service, no maskable source is offered. A level held high does not raise it again.
- R9: An end-of-interrupt clears exactly one in-service bit: the one of the most urgent in-service source, with NMI first, then lowest priority value, then lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 11 | Level requests of the maskable sources, bit i = source i |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Source index being configured; 11 to 15 ignored |
| cfg_wdata_i | input | 5 | Priority [2:0], mask [3], special nesting [4] |
| irq_o | output | 1 | Interrupt offered to the core |
| irq_type_o | output | 8 | Type code of the offered source |
| ack_i | input | 1 | Core accepts the offered interrupt |
| eoi_i | input | 1 | End-of-interrupt from the core |

## Verification
A request, a withdrawn request or a latched NMI edge shows on `irq_o` one clock after it is sampled. A configuration write and an end-of-interrupt each need two clocks, because the controller first updates its stored state and only then re-evaluates the winner. After an acknowledge, `irq_o` is low on the next clock, and any re-offer appears one clock after that. The bench drives every input on the falling edge, counts the rising edges to the result and samples on the falling edge where the result is due. Each scenario that depends on the in-service state also checks the cycle before the re-offer is allowed.

// File: rtl/nic_pkg.sv
package nic_pkg;
    parameter int unsigned PRIO_W = 3;
    parameter int unsigned CFG_W  = PRIO_W + 2;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              mask;
        logic              sfn;
    } src_cfg_t;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_pkg::*;
#(
    parameter int unsigned N_MASK = 11,
    parameter int unsigned N_SFN  = 2,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output src_cfg_t          cfg_o [N_MASK]
);
    src_cfg_t cfg_d [N_MASK];
    src_cfg_t cfg_q [N_MASK];

    always_comb begin
        for (int i = 0; i < N_MASK; i++) begin
            cfg_d[i] = cfg_q[i];
            if (we_i && addr_i == ADDR_W'(i)) begin
                cfg_d[i].prio = wdata_i[PRIO_W-1:0];
                cfg_d[i].mask = wdata_i[PRIO_W];
                cfg_d[i].sfn  = (i < N_SFN) ? wdata_i[PRIO_W+1] : 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MASK; i++) begin
                cfg_q[i] <= '{prio: '1, mask: 1'b1, sfn: 1'b0};
            end
        end else begin
            for (int i = 0; i < N_MASK; i++) begin
                cfg_q[i] <= cfg_d[i];
            end
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/nic_min_pick.sv
module nic_min_pick #(
    parameter int unsigned N  = 12,
    parameter int unsigned RW = 4,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  valid_i,
    input  logic [RW-1:0] rank_i [N],
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    logic [RW-1:0] best;

    // Strict compare keeps the first (lowest) index on equal rank.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!found_o || rank_i[i] < best)) begin
                found_o = 1'b1;
                best    = rank_i[i];
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int unsigned N_MASK    = 11,
    parameter int unsigned N_SFN     = 2,
    parameter int unsigned ADDR_W    = 4,
    parameter logic [7:0]  TYPE_BASE = 8'h20,
    parameter logic [7:0]  NMI_TYPE  = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MASK-1:0] req_i,
    input  logic              nmi_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              irq_o,
    output logic [7:0]        irq_type_o,
    input  logic              ack_i,
    input  logic              eoi_i
);
    localparam int unsigned NSRC    = N_MASK + 1;
    localparam int unsigned NMI_IDX = N_MASK;
    localparam int unsigned IDX_W   = $clog2(NSRC);
    localparam int unsigned RANK_W  = PRIO_W + 1;

    typedef struct packed {
        logic [NSRC-1:0]  isr;
        logic             nmi_pend;
        logic             nmi_prev;
        logic             irq;
        logic [IDX_W-1:0] cand;
        logic [7:0]       typ;
    } state_t;

    state_t st_d, st_q;

    src_cfg_t          cfg [N_MASK];
    logic [RANK_W-1:0] rank [NSRC];
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   sfn_on;
    logic [NSRC-1:0]   elig;
    logic [RANK_W-1:0] thr;
    logic              win_found, top_found;
    logic [IDX_W-1:0]  win_idx, top_idx;

    nic_cfg_regs #(
        .N_MASK (N_MASK),
        .N_SFN  (N_SFN),
        .ADDR_W (ADDR_W)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    // Rank 0 belongs to NMI; maskable sources sit at 1 + programmed priority.
    always_comb begin
        for (int i = 0; i < N_MASK; i++) begin
            rank[i]   = RANK_W'(cfg[i].prio) + RANK_W'(1);
            pend[i]   = req_i[i] && !cfg[i].mask;
            sfn_on[i] = cfg[i].sfn;
        end
        rank[NMI_IDX]   = '0;
        pend[NMI_IDX]   = st_q.nmi_pend;
        sfn_on[NMI_IDX] = 1'b0;
    end

    // Most urgent entry in service: threshold for nesting and EOI target.
    nic_min_pick #(
        .N  (NSRC),
        .RW (RANK_W),
        .IW (IDX_W)
    ) i_top_pick (
        .valid_i (st_q.isr),
        .rank_i  (rank),
        .found_o (top_found),
        .idx_o   (top_idx)
    );

    assign thr = top_found ? rank[top_idx] : '1;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend[i] &&
                      ((!st_q.isr[i] && rank[i] < thr) ||
                       (sfn_on[i] && rank[i] <= thr));
        end
    end

    nic_min_pick #(
        .N  (NSRC),
        .RW (RANK_W),
        .IW (IDX_W)
    ) i_win_pick (
        .valid_i (elig),
        .rank_i  (rank),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    always_comb begin
        logic took;
        st_d = st_q;
        took = ack_i && st_q.irq;

        st_d.nmi_prev = nmi_i;
        if (took && st_q.cand == IDX_W'(NMI_IDX)) begin
            st_d.nmi_pend = 1'b0;
        end
        if (nmi_i && !st_q.nmi_prev) begin
            st_d.nmi_pend = 1'b1;
        end

        if (eoi_i && top_found) begin
            st_d.isr[top_idx] = 1'b0;
        end
        if (took) begin
            st_d.isr[st_q.cand] = 1'b1;
        end

        // Withdraw for one cycle after acceptance so the winner is
        // re-evaluated against the updated in-service set.
        st_d.irq = win_found && !took;
        if (win_found) begin
            st_d.cand = win_idx;
            st_d.typ  = (win_idx == IDX_W'(NMI_IDX)) ? NMI_TYPE
                                                     : TYPE_BASE + 8'(win_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign irq_type_o = st_q.typ;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int unsigned N_MASK    = 11,
    parameter int unsigned N_SFN     = 2,
    parameter logic [7:0]  TYPE_BASE = 8'h20,
    parameter logic [7:0]  NMI_TYPE  = 8'h02,
    parameter int unsigned NSRC      = N_MASK + 1,
    parameter int unsigned IDX_W     = $clog2(N_MASK + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [7:0]       irq_type_o,
    input logic             ack_i,
    input logic             eoi_i,
    input logic [NSRC-1:0]  isr_q,
    input logic [IDX_W-1:0] cand_q
);
    a_r2_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_type_o == NMI_TYPE) ||
                  (irq_type_o >= TYPE_BASE && irq_type_o < TYPE_BASE + 8'(N_MASK)));

    a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> isr_q[$past(cand_q)]);

    a_r5_ack_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !irq_o);

    a_r7_self_block: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!isr_q[cand_q] || cand_q < IDX_W'(N_SFN)));

    a_r9_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && (isr_q != '0)) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind nest_irq_ctrl nic_checker #(
    .N_MASK    (N_MASK),
    .N_SFN     (N_SFN),
    .TYPE_BASE (TYPE_BASE),
    .NMI_TYPE  (NMI_TYPE)
) i_nic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .irq_type_o (irq_type_o),
    .ack_i      (ack_i),
    .eoi_i      (eoi_i),
    .isr_q      (st_q.isr),
    .cand_q     (st_q.cand)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] req = '0;
    logic        nmi = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic        irq;
    logic [7:0]  irq_type;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .nmi_i       (nmi),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .irq_o       (irq),
        .irq_type_o  (irq_type),
        .ack_i       (ack),
        .eoi_i       (eoi)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(input logic exp_irq, input logic [7:0] exp_type,
                              input string tag);
        checks++;
        if (irq !== exp_irq || (exp_irq && irq_type !== exp_type)) begin
            failures++;
            $display("FAIL %s: irq=%0b type=%02h expected irq=%0b type=%02h",
                     tag, irq, irq_type, exp_irq, exp_type);
        end
    endtask

    task automatic wr(input int src, input int prio, input bit msk, input bit sfn);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(src);
        cfg_wdata = {sfn, msk, 3'(prio)};
        step(1);
        cfg_we    = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        step(1);
        eoi = 1'b0;
    endtask

    task automatic t_reset();
        expect_irq(1'b0, 8'h00, "R1 idle after reset");
        req = '1;
        step(2);
        expect_irq(1'b0, 8'h00, "R1 all sources masked by default");
        req = '0;
        step(1);
    endtask

    task automatic t_basic();
        wr(5, 3, 1'b0, 1'b0);
        req[5] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h25, "R2 timer source offered");
        do_ack();
        expect_irq(1'b0, 8'h00, "R5 withdrawn after ack");
        step(2);
        expect_irq(1'b0, 8'h00, "R5 same source blocked while in service");
        do_eoi();
        step(1);
        expect_irq(1'b1, 8'h25, "R9 eoi releases the source");
        req[5] = 1'b0;
        step(1);
        expect_irq(1'b0, 8'h00, "R2 drop after request withdrawn");
    endtask

    task automatic t_mask();
        wr(6, 2, 1'b1, 1'b0);
        req[6] = 1'b1;
        step(2);
        expect_irq(1'b0, 8'h00, "R3 masked source ignored");
        wr(6, 2, 1'b0, 1'b0);
        step(1);
        expect_irq(1'b1, 8'h26, "R3 unmask takes effect");
        req[6] = 1'b0;
        wr(6, 2, 1'b1, 1'b0);
        step(1);
    endtask

    task automatic t_priority();
        wr(2, 4, 1'b0, 1'b0);
        wr(7, 1, 1'b0, 1'b0);
        wr(8, 1, 1'b0, 1'b0);
        req[2] = 1'b1; req[7] = 1'b1; req[8] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h27, "R4 tie goes to lower index");
        req[7] = 1'b0;
        step(1);
        expect_irq(1'b1, 8'h28, "R4 lower value beats higher");
        req[8] = 1'b0;
        step(1);
        expect_irq(1'b1, 8'h22, "R4 remaining source");
        req[2] = 1'b0;
        step(1);
        expect_irq(1'b0, 8'h00, "R2 all withdrawn");
    endtask

    task automatic t_nest();
        wr(3, 5, 1'b0, 1'b0);
        wr(4, 5, 1'b0, 1'b0);
        wr(9, 2, 1'b0, 1'b0);
        req[3] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h23, "R2 source 3 offered");
        do_ack();
        req[3] = 1'b0;
        req[4] = 1'b1;
        step(2);
        expect_irq(1'b0, 8'h00, "R6 equal priority waits");
        req[9] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h29, "R6 higher priority nests");
        do_ack();
        step(1);
        expect_irq(1'b0, 8'h00, "R6 nothing eligible with 3 and 9 in service");
        do_eoi();
        step(1);
        expect_irq(1'b1, 8'h29, "R9 eoi retired the most urgent entry");
        do_ack();
        req[9] = 1'b0;
        do_eoi();
        do_eoi();
        step(1);
        expect_irq(1'b1, 8'h24, "R9 second eoi retires source 3");
        req[4] = 1'b0;
        step(1);
        expect_irq(1'b0, 8'h00, "R2 idle after nesting");
    endtask

    task automatic t_sfn();
        wr(0, 3, 1'b0, 1'b1);
        req[0] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h20, "R7 external line 0 offered");
        do_ack();
        step(1);
        expect_irq(1'b1, 8'h20, "R7 special nesting re-offers while in service");
        do_ack();
        req[0] = 1'b0;
        do_eoi();
        step(1);
        expect_irq(1'b0, 8'h00, "R7 idle after special nesting");
        wr(0, 3, 1'b1, 1'b0);
        wr(10, 3, 1'b0, 1'b1);
        req[10] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h2A, "R2 serial source offered");
        do_ack();
        step(2);
        expect_irq(1'b0, 8'h00, "R7 nesting bit ignored on source 10");
        req[10] = 1'b0;
        do_eoi();
        step(2);
        expect_irq(1'b0, 8'h00, "R9 single eoi empties in-service set");
    endtask

    task automatic t_nmi();
        nmi = 1'b1;
        step(1);
        nmi = 1'b0;
        step(1);
        expect_irq(1'b1, 8'h02, "R8 nmi offered without mask");
        do_ack();
        do_eoi();
        wr(1, 0, 1'b0, 1'b0);
        req[1] = 1'b1;
        step(1);
        expect_irq(1'b1, 8'h21, "R4 priority 0 source offered");
        nmi = 1'b1;
        step(2);
        expect_irq(1'b1, 8'h02, "R8 nmi outranks priority 0");
        do_ack();
        step(2);
        expect_irq(1'b0, 8'h00, "R8 nmi in service blocks all, level not re-armed");
        do_eoi();
        step(1);
        expect_irq(1'b1, 8'h21, "R9 eoi retires nmi");
        do_ack();
        req[1] = 1'b0;
        do_eoi();
        nmi = 1'b0;
        step(2);
        expect_irq(1'b0, 8'h00, "R8 idle after nmi");
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_basic();
        t_mask();
        t_priority();
        t_nest();
        t_sfn();
        t_nmi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule